// File: doc/BRIEF.md
# Open-Page DRAM Latency Predictor

This block estimates, one request at a time, how many CPU cycles a memory access to an open-page SDRAM will cost. Each request carries an address, a byte count and a read/write flag. The block maps the address to a bank and a row, using either a linear or a row-interleaved map. It compares the request with the one accepted before it: same direction or not, same bank or not, same row or not. It then measures how much of the target bank's outstanding busy window is still ahead of the current tick. From these facts and a set of static timing inputs (column access, precharge, activate, write recovery and write-to-read turnaround) it picks a latency.

The result is returned one cycle after the request, together with the burst length. The block also keeps running totals of idle time, read and write burst beats, and accepted accesses. A free-running tick counter serves as the time base and is visible at the ports, so a caller can line up requests with the busy windows.

A small two-state machine holds the response. In `ST_IDLE` no result is pending. An accepted request takes `T_ACCEPT` into `ST_RESP`, which presents the result for exactly one cycle. From `ST_RESP` a further accepted request takes `T_ACCEPT` again and stays in `ST_RESP`; with no request, `T_DRAIN` returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `dram_lat_predictor`

## Requirements
- R1: `req_ready` is 1 whenever reset is low. `resp_valid` is 1 in the cycle right after each accepted request and 0 after any cycle without one. One request can be accepted every cycle.
- R2: The burst length is the byte count divided by the bus width (4 bytes by default), rounded up. A zero byte count returns `resp_err`=1, latency 0 and burst 0. Such a request changes no counter, no history and no bank busy time.
- R3: With `cfg_interleave`=0, the bank is (address / bank size) modulo the number of banks, and the row is (address modulo bank size) / row size. The defaults are a 4096-byte bank, a 64-byte row and 4 banks.
- R4: With `cfg_interleave`=1, the block number is address / row size, the bank is the block modulo the number of banks, and the row is the block / number of banks.
- R5: The overlap is busy-until of the target bank minus the current tick when `cfg_pipe_en`=1 and that difference is positive; otherwise it is 0. It is converted to CPU cycles by shifting right by `cfg_ratio_shift`, or left when `cfg_ratio_below_one`=1, and then saturated to the latency width.
- R6: A read after a read to the same bank and row costs 0 if the overlap is at least CAS, CAS minus the overlap if the overlap is between 1 and CAS-1, and CAS if there is no overlap.
- R7: A write after a write to the same bank and row costs 0.
- R8: In the same bank but a different row, a read after a read costs ACT+CAS if the overlap is at least PRE, PRE+ACT+CAS minus the overlap for a smaller non-zero overlap, and PRE+ACT+CAS with no overlap. A write after a write costs PRE+ACT+DPL-1.
- R9: The first request after reset costs PRE+ACT+CAS for a read and PRE+ACT for a write. A same-direction request to a different bank costs 0 if the overlap is non-zero, and otherwise PRE+ACT+CAS for a read or PRE+ACT for a write.
- R10: When the direction changes, the costs are as follows. In the same row: CAS for a read, WAR-1 for a write. In the same bank and another row: PRE+ACT+CAS+DPL-1 for a read, PRE+ACT for a write. In another bank with a non-zero overlap: CAS for a read, WAR-1 for a write. In another bank without overlap: PRE+ACT+CAS for a read, PRE+ACT for a write.
- R11: For a valid request where the current tick is later than the target bank's busy-until, `idle_cycles` grows by the smaller of (tick - busy-until) and (tick - tick of the previous valid request). Both reference times are 0 after reset.
- R12: Each valid request adds its burst length to `read_cycles` or `write_cycles` according to its direction, and adds 1 to `access_count`. No counter changes in a cycle without a request.
- R13: A valid request sets its bank's busy-until to the current tick plus the returned latency. It also records its direction, bank, row and tick as the history for the next request.
- R14: After reset, `now_tick`, all counters and `resp_valid` are 0. `now_tick` then advances by 1 every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SIZE_W | Transfer size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_interleave | input | 1 | 1 = interleaved map, 0 = linear map |
| cfg_pipe_en | input | 1 | Enable overlap with the bank busy window |
| cfg_ratio_below_one | input | 1 | Shift the overlap left instead of right |
| cfg_ratio_shift | input | 3 | log2 of the clock ratio |
| cfg_t_cas | input | TW | Column access time |
| cfg_t_pre | input | TW | Precharge time |
| cfg_t_act | input | TW | Activate time |
| cfg_t_dpl | input | TW | Write recovery time |
| cfg_t_war | input | TW | Write-to-read turnaround |
| resp_valid | output | 1 | Result present |
| resp_latency | output | LAT_W | Predicted latency in CPU cycles |
| resp_burst | output | BURST_W | Burst length in bus beats |
| resp_err | output | 1 | Zero-size request |
| now_tick | output | TIME_W | Current tick |
| idle_cycles | output | CNT_W | Accumulated idle time |
| read_cycles | output | CNT_W | Accumulated read beats |
| write_cycles | output | CNT_W | Accumulated write beats |
| access_count | output | CNT_W | Accepted valid requests |

## Verification
The properties assume that the timing inputs and mode bits stay fixed between resets, and that WAR and DPL are at least 1 so the minus-one terms cannot wrap. They also assume that every latency sum fits in `LAT_W` and that `now_tick` never wraps within a run. The stimulus sets all configuration while reset is high, uses small timing values (CAS 3, PRE/ACT/DPL/WAR 2) and keeps each run to a few hundred ticks. Each run repeats one request sequence under four mode combinations, so the same address pattern yields row hits under one map and other-bank accesses under the other.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } dlp_state_e;

    // Relation of a request to the previous accepted one.
    // HS_* : same direction, HX_* : direction changed.
    typedef enum logic [2:0] {
        HC_FIRST      = 3'd0,
        HS_ROW_HIT    = 3'd1,
        HS_ROW_MISS   = 3'd2,
        HS_OTHER_BANK = 3'd3,
        HX_ROW_HIT    = 3'd4,
        HX_ROW_MISS   = 3'd5,
        HX_OTHER_BANK = 3'd6
    } hit_class_e;

endpackage

// File: rtl/dlp_addr_map.sv
module dlp_addr_map #(
    parameter int ADDR_W  = 16,
    parameter int ROW_LG  = 6,
    parameter int BANK_LG = 12,
    parameter int NB_LG   = 2,
    parameter int ROW_W   = ADDR_W - ROW_LG
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              interleave,
    output logic [NB_LG-1:0]  bank,
    output logic [ROW_W-1:0]  row
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << BANK_LG) - 64'd1);

    logic [ADDR_W-1:0] in_bank_off;
    logic [ADDR_W-1:0] block;
    logic [NB_LG-1:0]  lin_bank, il_bank;
    logic [ROW_W-1:0]  lin_row, il_row;

    always_comb begin
        in_bank_off = addr & OFF_MASK;
        lin_bank    = NB_LG'(addr >> BANK_LG);
        lin_row     = ROW_W'(in_bank_off >> ROW_LG);
        block       = addr >> ROW_LG;
        il_bank     = NB_LG'(block);
        il_row      = ROW_W'(block >> NB_LG);
        bank        = interleave ? il_bank : lin_bank;
        row         = interleave ? il_row  : lin_row;
    end

endmodule

// File: rtl/dlp_overlap.sv
module dlp_overlap #(
    parameter int TIME_W = 32,
    parameter int LAT_W  = 8
) (
    input  logic [TIME_W-1:0] busy_until,
    input  logic [TIME_W-1:0] now,
    input  logic              pipe_en,
    input  logic              below_one,
    input  logic [2:0]        shift,
    output logic [LAT_W-1:0]  ov_cpu
);
    localparam int EXT_W = TIME_W + 8;
    localparam logic [EXT_W-1:0] LAT_MAX = EXT_W'((64'd1 << LAT_W) - 64'd1);

    logic [TIME_W-1:0] raw;
    logic [EXT_W-1:0]  ext;
    logic [EXT_W-1:0]  conv;

    always_comb begin
        raw    = (pipe_en && (busy_until > now)) ? (busy_until - now) : '0;
        ext    = EXT_W'(raw);
        conv   = below_one ? (ext << shift) : (ext >> shift);
        ov_cpu = (conv > LAT_MAX) ? '1 : LAT_W'(conv);
    end

endmodule

// File: rtl/dlp_lat_select.sv
module dlp_lat_select
    import dlp_pkg::*;
#(
    parameter int TW    = 4,
    parameter int LAT_W = 8
) (
    input  hit_class_e        cls,
    input  logic              is_write,
    input  logic [LAT_W-1:0]  ov,
    input  logic [TW-1:0]     t_cas,
    input  logic [TW-1:0]     t_pre,
    input  logic [TW-1:0]     t_act,
    input  logic [TW-1:0]     t_dpl,
    input  logic [TW-1:0]     t_war,
    output logic [LAT_W-1:0]  lat
);
    logic [LAT_W-1:0] c, p, a, d, w;
    logic [LAT_W-1:0] pa, pac, ac;
    logic             ov_any;

    always_comb begin
        c      = LAT_W'(t_cas);
        p      = LAT_W'(t_pre);
        a      = LAT_W'(t_act);
        d      = LAT_W'(t_dpl);
        w      = LAT_W'(t_war);
        pa     = p + a;
        pac    = pa + c;
        ac     = a + c;
        ov_any = (ov != '0);
        lat    = '0;
        unique case (cls)
            HC_FIRST:      lat = is_write ? pa : pac;
            HS_ROW_HIT: begin
                if (is_write)     lat = '0;
                else if (ov >= c) lat = '0;
                else if (ov_any)  lat = c - ov;
                else              lat = c;
            end
            HS_ROW_MISS: begin
                if (is_write)     lat = pa + d - 1'b1;
                else if (ov >= p) lat = ac;
                else if (ov_any)  lat = pac - ov;
                else              lat = pac;
            end
            HS_OTHER_BANK: lat = ov_any ? '0 : (is_write ? pa : pac);
            HX_ROW_HIT:    lat = is_write ? (w - 1'b1) : c;
            HX_ROW_MISS:   lat = is_write ? pa : (pac + d - 1'b1);
            HX_OTHER_BANK: begin
                if (ov_any) lat = is_write ? (w - 1'b1) : c;
                else        lat = is_write ? pa : pac;
            end
            default:       lat = '0;
        endcase
    end

endmodule

// File: rtl/dlp_counters.sv
module dlp_counters #(
    parameter int TIME_W  = 32,
    parameter int CNT_W   = 32,
    parameter int BURST_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd,
    input  logic               is_write,
    input  logic [BURST_W-1:0] burst,
    input  logic               idle_en,
    input  logic [TIME_W-1:0]  idle_add,
    output logic [CNT_W-1:0]   idle_cnt,
    output logic [CNT_W-1:0]   rd_cnt,
    output logic [CNT_W-1:0]   wr_cnt,
    output logic [CNT_W-1:0]   acc_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            rd_cnt   <= '0;
            wr_cnt   <= '0;
            acc_cnt  <= '0;
        end else if (upd) begin
            acc_cnt <= acc_cnt + 1'b1;
            if (idle_en) idle_cnt <= idle_cnt + CNT_W'(idle_add);
            if (is_write) wr_cnt <= wr_cnt + CNT_W'(burst);
            else          rd_cnt <= rd_cnt + CNT_W'(burst);
        end
    end

endmodule

// File: rtl/dram_lat_predictor.sv
module dram_lat_predictor
    import dlp_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 8,
    parameter int BUS_LG     = 2,
    parameter int ROW_LG     = 6,
    parameter int BANK_LG    = 12,
    parameter int NB_LG      = 2,
    parameter int TW         = 4,
    parameter int LAT_W      = 8,
    parameter int TIME_W     = 32,
    parameter int CNT_W      = 32,
    parameter int BURST_W    = SIZE_W - BUS_LG + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic               req_write,
    input  logic               cfg_interleave,
    input  logic               cfg_pipe_en,
    input  logic               cfg_ratio_below_one,
    input  logic [2:0]         cfg_ratio_shift,
    input  logic [TW-1:0]      cfg_t_cas,
    input  logic [TW-1:0]      cfg_t_pre,
    input  logic [TW-1:0]      cfg_t_act,
    input  logic [TW-1:0]      cfg_t_dpl,
    input  logic [TW-1:0]      cfg_t_war,
    output logic               resp_valid,
    output logic [LAT_W-1:0]   resp_latency,
    output logic [BURST_W-1:0] resp_burst,
    output logic               resp_err,
    output logic [TIME_W-1:0]  now_tick,
    output logic [CNT_W-1:0]   idle_cycles,
    output logic [CNT_W-1:0]   read_cycles,
    output logic [CNT_W-1:0]   write_cycles,
    output logic [CNT_W-1:0]   access_count
);
    localparam int NUM_BANKS = 1 << NB_LG;
    localparam int ROW_W     = ADDR_W - ROW_LG;
    localparam int SUM_W     = SIZE_W + 1;
    localparam int BUS_BYTES = 1 << BUS_LG;

    dlp_state_e state_q, state_d;

    logic               accept, size_ok, upd;
    logic [SUM_W-1:0]   size_round;
    logic [BURST_W-1:0] burst;
    logic [NB_LG-1:0]   bank;
    logic [ROW_W-1:0]   row;
    logic [TIME_W-1:0]  busy_q [NUM_BANKS];
    logic [TIME_W-1:0]  busy_sel;
    logic [LAT_W-1:0]   ov_cpu, lat;
    hit_class_e         cls;

    logic               hist_q, last_wr_q;
    logic [NB_LG-1:0]   last_bank_q;
    logic [ROW_W-1:0]   last_row_q;
    logic [TIME_W-1:0]  last_time_q;

    logic               was_idle;
    logic [TIME_W-1:0]  gap_busy, gap_last, idle_add;

    // ---------------- request acceptance ----------------
    assign req_ready  = ~rst;
    assign accept     = req_valid & req_ready;
    assign size_ok    = (req_size != '0);
    assign upd        = accept & size_ok;
    assign size_round = SUM_W'(req_size) + SUM_W'(BUS_BYTES - 1);
    assign burst      = BURST_W'(size_round >> BUS_LG);

    // ---------------- tick counter ----------------
    always_ff @(posedge clk) begin
        if (rst) now_tick <= '0;
        else     now_tick <= now_tick + 1'b1;
    end

    // ---------------- address map ----------------
    dlp_addr_map #(
        .ADDR_W(ADDR_W), .ROW_LG(ROW_LG), .BANK_LG(BANK_LG),
        .NB_LG(NB_LG), .ROW_W(ROW_W)
    ) u_map (
        .addr(req_addr), .interleave(cfg_interleave), .bank(bank), .row(row)
    );

    // ---------------- per-bank busy windows ----------------
    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rst)
                busy_q[b] <= '0;
            else if (upd && (bank == NB_LG'(b)))
                busy_q[b] <= now_tick + TIME_W'(lat);
        end
    end

    assign busy_sel = busy_q[bank];

    dlp_overlap #(.TIME_W(TIME_W), .LAT_W(LAT_W)) u_ov (
        .busy_until(busy_sel), .now(now_tick), .pipe_en(cfg_pipe_en),
        .below_one(cfg_ratio_below_one), .shift(cfg_ratio_shift), .ov_cpu(ov_cpu)
    );

    // ---------------- classification ----------------
    always_comb begin
        if (!hist_q)
            cls = HC_FIRST;
        else if (req_write == last_wr_q) begin
            if (bank != last_bank_q)     cls = HS_OTHER_BANK;
            else if (row != last_row_q)  cls = HS_ROW_MISS;
            else                         cls = HS_ROW_HIT;
        end else begin
            if (bank != last_bank_q)     cls = HX_OTHER_BANK;
            else if (row != last_row_q)  cls = HX_ROW_MISS;
            else                         cls = HX_ROW_HIT;
        end
    end

    dlp_lat_select #(.TW(TW), .LAT_W(LAT_W)) u_sel (
        .cls(cls), .is_write(req_write), .ov(ov_cpu),
        .t_cas(cfg_t_cas), .t_pre(cfg_t_pre), .t_act(cfg_t_act),
        .t_dpl(cfg_t_dpl), .t_war(cfg_t_war), .lat(lat)
    );

    // ---------------- history ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q      <= 1'b0;
            last_wr_q   <= 1'b0;
            last_bank_q <= '0;
            last_row_q  <= '0;
            last_time_q <= '0;
        end else if (upd) begin
            hist_q      <= 1'b1;
            last_wr_q   <= req_write;
            last_bank_q <= bank;
            last_row_q  <= row;
            last_time_q <= now_tick;
        end
    end

    // ---------------- idle accounting ----------------
    always_comb begin
        was_idle = (now_tick > busy_sel);
        gap_busy = now_tick - busy_sel;
        gap_last = now_tick - last_time_q;
        idle_add = (gap_busy < gap_last) ? gap_busy : gap_last;
    end

    dlp_counters #(.TIME_W(TIME_W), .CNT_W(CNT_W), .BURST_W(BURST_W)) u_cnt (
        .clk(clk), .rst(rst), .upd(upd), .is_write(req_write), .burst(burst),
        .idle_en(was_idle), .idle_add(idle_add),
        .idle_cnt(idle_cycles), .rd_cnt(read_cycles),
        .wr_cnt(write_cycles), .acc_cnt(access_count)
    );

    // ---------------- response state machine ----------------
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = accept ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_latency <= '0;
            resp_burst   <= '0;
            resp_err     <= 1'b0;
        end else if (accept) begin
            resp_latency <= size_ok ? lat : '0;
            resp_burst   <= size_ok ? burst : '0;
            resp_err     <= ~size_ok;
        end
    end

    assign resp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/dlp_checker.sv
module dlp_checker #(
    parameter int LAT_W   = 8,
    parameter int BURST_W = 7,
    parameter int TIME_W  = 32,
    parameter int CNT_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_err,
    input logic [LAT_W-1:0]   resp_latency,
    input logic [BURST_W-1:0] resp_burst,
    input logic [TIME_W-1:0]  now_tick,
    input logic [CNT_W-1:0]   idle_cycles,
    input logic [CNT_W-1:0]   read_cycles,
    input logic [CNT_W-1:0]   write_cycles,
    input logic [CNT_W-1:0]   access_count
);
    // R1
    resp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);

    // R1
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !resp_valid);

    // R2
    err_zero_result_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |-> (resp_latency == '0 && resp_burst == '0));

    // R2
    burst_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_err) |-> (resp_burst != '0));

    // R14
    tick_advance_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (now_tick == $past(now_tick) + 1'b1));

    // R12
    counters_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(idle_cycles) && $stable(read_cycles)
                        && $stable(write_cycles) && $stable(access_count)));

    // R12
    access_step_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_err) |-> (access_count == $past(access_count) + 1'b1));

    // R12
    beat_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_err) |->
        ((read_cycles - $past(read_cycles)) + (write_cycles - $past(write_cycles))
         == CNT_W'(resp_burst)));

endmodule

bind dram_lat_predictor dlp_checker #(
    .LAT_W(LAT_W), .BURST_W(BURST_W), .TIME_W(TIME_W), .CNT_W(CNT_W)
) u_dlp_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_latency(resp_latency),
    .resp_burst(resp_burst), .now_tick(now_tick), .idle_cycles(idle_cycles),
    .read_cycles(read_cycles), .write_cycles(write_cycles),
    .access_count(access_count)
);

// File: tb/test_dram_lat_predictor.sv
module test_dram_lat_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    localparam int C_CAS = 3, C_PRE = 2, C_ACT = 2, C_DPL = 2, C_WAR = 2;

    // {gap[3:0], write, size[7:0], addr[15:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {4'd2, 1'b0, 8'd4,   16'h0000},
        {4'd0, 1'b0, 8'd4,   16'h0004},
        {4'd0, 1'b0, 8'd8,   16'h0008},
        {4'd3, 1'b0, 8'd4,   16'h0010},
        {4'd0, 1'b0, 8'd32,  16'h0040},
        {4'd0, 1'b1, 8'd5,   16'h0080},
        {4'd0, 1'b1, 8'd4,   16'h0084},
        {4'd1, 1'b1, 8'd4,   16'h1000},
        {4'd0, 1'b0, 8'd4,   16'h1000},
        {4'd0, 1'b1, 8'd255, 16'h1100},
        {4'd2, 1'b0, 8'd1,   16'h2000},
        {4'd0, 1'b0, 8'd4,   16'h2040},
        {4'd4, 1'b0, 8'd4,   16'h2000},
        {4'd0, 1'b1, 8'd4,   16'h3000},
        {4'd0, 1'b0, 8'd4,   16'h0000},
        {4'd1, 1'b0, 8'd16,  16'h0100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        cfg_interleave = 1'b0, cfg_pipe_en = 1'b1, cfg_ratio_below_one = 1'b0;
    logic [2:0]  cfg_ratio_shift = '0;
    logic        resp_valid, resp_err;
    logic [7:0]  resp_latency;
    logic [6:0]  resp_burst;
    logic [31:0] now_tick, idle_cycles, read_cycles, write_cycles, access_count;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // reference state
    longint m_busy [4];
    bit     m_hist, m_last_wr;
    int     m_last_bank, m_last_row;
    longint m_last_t, m_idle, m_rd, m_wr, m_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_lat_predictor i_dram_lat_predictor (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .cfg_interleave(cfg_interleave), .cfg_pipe_en(cfg_pipe_en),
        .cfg_ratio_below_one(cfg_ratio_below_one), .cfg_ratio_shift(cfg_ratio_shift),
        .cfg_t_cas(4'(C_CAS)), .cfg_t_pre(4'(C_PRE)), .cfg_t_act(4'(C_ACT)),
        .cfg_t_dpl(4'(C_DPL)), .cfg_t_war(4'(C_WAR)),
        .resp_valid(resp_valid), .resp_latency(resp_latency), .resp_burst(resp_burst),
        .resp_err(resp_err), .now_tick(now_tick), .idle_cycles(idle_cycles),
        .read_cycles(read_cycles), .write_cycles(write_cycles),
        .access_count(access_count)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int b = 0; b < 4; b++) m_busy[b] = 0;
        m_hist = 0; m_last_wr = 0; m_last_bank = 0; m_last_row = 0;
        m_last_t = 0; m_idle = 0; m_rd = 0; m_wr = 0; m_acc = 0;
    endtask

    // Computes the expected result and advances the reference state.
    task automatic model_req(input int addr, input int size, input bit wr, input longint now,
                             output int lat, output int burst, output bit err,
                             output string cls);
        int bank, row, ov, pac, pa;
        longint raw, conv;
        bit same_dir;
        if (size == 0) begin
            lat = 0; burst = 0; err = 1; cls = "R2";
            return;
        end
        err = 0;
        burst = (size + 3) / 4;
        if (cfg_interleave) begin
            bank = (addr / 64) % 4; row = (addr / 64) / 4;
        end else begin
            bank = (addr / 4096) % 4; row = (addr % 4096) / 64;
        end
        raw = (cfg_pipe_en && m_busy[bank] > now) ? m_busy[bank] - now : 0;
        conv = cfg_ratio_below_one ? raw * (longint'(1) << cfg_ratio_shift)
                                   : raw / (longint'(1) << cfg_ratio_shift);
        ov = (conv > 255) ? 255 : int'(conv);
        pa = C_PRE + C_ACT; pac = pa + C_CAS;
        same_dir = (wr == m_last_wr);
        if (!m_hist) begin
            cls = "R9"; lat = wr ? pa : pac;
        end else if (bank != m_last_bank) begin
            if (same_dir) begin cls = "R9";  lat = (ov > 0) ? 0 : (wr ? pa : pac); end
            else begin cls = "R10"; lat = (ov > 0) ? (wr ? C_WAR - 1 : C_CAS) : (wr ? pa : pac); end
        end else if (row != m_last_row) begin
            if (!same_dir) begin cls = "R10"; lat = wr ? pa : pac + C_DPL - 1; end
            else if (wr) begin cls = "R8"; lat = pa + C_DPL - 1; end
            else begin
                cls = "R8";
                lat = (ov >= C_PRE) ? C_ACT + C_CAS : (ov > 0 ? pac - ov : pac);
            end
        end else begin
            if (!same_dir) begin cls = "R10"; lat = wr ? C_WAR - 1 : C_CAS; end
            else if (wr) begin cls = "R7"; lat = 0; end
            else begin
                cls = "R6";
                lat = (ov >= C_CAS) ? 0 : (ov > 0 ? C_CAS - ov : C_CAS);
            end
        end
        if (now > m_busy[bank])
            m_idle += ((now - m_busy[bank]) < (now - m_last_t)) ? (now - m_busy[bank])
                                                                : (now - m_last_t);
        if (wr) m_wr += burst; else m_rd += burst;
        m_acc++;
        m_busy[bank] = now + lat;
        m_hist = 1; m_last_wr = wr; m_last_bank = bank; m_last_row = row; m_last_t = now;
    endtask

    // Drives one request at a negedge and checks the response one cycle later.
    task automatic do_req(input int addr, input int size, input bit wr, input string ctag);
        int elat, eburst;
        bit eerr;
        string cls;
        req_valid = 1; req_addr = 16'(addr); req_size = 8'(size); req_write = wr;
        check("R1 ready", req_ready, 1);
        model_req(addr, size, wr, longint'(now_tick), elat, eburst, eerr, cls);
        @(posedge clk); @(negedge clk);
        check("R1 resp_valid", resp_valid, 1);
        check($sformatf("%s %s R13 latency addr=%h", cls, ctag, addr), resp_latency, elat);
        check("R2 burst", resp_burst, eburst);
        check("R2 err", resp_err, eerr);
    endtask

    task automatic idle_cycle();
        req_valid = 0;
        @(posedge clk); @(negedge clk);
        check("R1 no response", resp_valid, 0);
    endtask

    task automatic do_reset();
        rst = 1; req_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_clear();
        check("R14 now_tick", now_tick, 0);
        check("R14 resp_valid", resp_valid, 0);
        check("R14 idle", idle_cycles, 0);
        check("R14 beats", read_cycles + write_cycles, 0);
        check("R14 access", access_count, 0);
    endtask

    task automatic check_counters(input string ctag);
        check($sformatf("R11 idle %s", ctag), idle_cycles, m_idle);
        check($sformatf("R12 read beats %s", ctag), read_cycles, m_rd);
        check($sformatf("R12 write beats %s", ctag), write_cycles, m_wr);
        check($sformatf("R12 accesses %s", ctag), access_count, m_acc);
    endtask

    initial begin
        @(negedge clk);
        for (int pass = 0; pass < 4; pass++) begin
            string ctag;
            longint t0;
            cfg_interleave      = (pass == 1 || pass == 3);
            cfg_pipe_en         = (pass != 3);
            cfg_ratio_below_one = (pass == 2);
            cfg_ratio_shift     = (pass == 1 || pass == 2) ? 3'd1 : 3'd0;
            ctag = $sformatf("%s%s", cfg_interleave ? "R4" : "R3",
                             (pass == 1 || pass == 2) ? " R5" : "");
            do_reset();
            for (int v = 0; v < NVEC; v++) begin
                for (int g = 0; g < int'(VEC[v][28:25]); g++) idle_cycle();
                do_req(int'(VEC[v][15:0]), int'(VEC[v][23:16]), VEC[v][24], ctag);
            end
            idle_cycle();
            check_counters(ctag);
            // zero-size request: error, nothing recorded (R2)
            do_req(16'h0000, 0, 1'b1, ctag);
            idle_cycle();
            check_counters("R2 unchanged");
            // the next request must still see the pre-error history
            do_req(16'h0100, 4, 1'b0, ctag);
            idle_cycle();
            t0 = longint'(now_tick);
            repeat (3) idle_cycle();
            check("R14 tick advance", now_tick, t0 + 3);
            check_counters("R12 hold");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule